// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block decides how a USB 2.0 device answers each transaction on its control endpoint (endpoint 0) and on up to three further endpoints. Token decoding, CRC checking and packet serialization happen elsewhere. The block receives a one-cycle token pulse with its kind and endpoint number, then a data-packet pulse with the received data PID and a CRC verdict, and finally a pulse when the host acknowledges data that the device sent. It also sees per-endpoint FIFO readiness. For each transaction it produces one registered response: ACK, NAK, STALL, a request to send a data packet with a given toggle, or silence. It also keeps the data toggle of every endpoint.

Firmware controls the block through four 8-bit registers. These hold the endpoint enables and directions, the halt bits, the toggle clears and toggle status, and the endpoint-0 status and lock. Endpoint 0 shuts itself against further OUT data after every good receive, and NAKs until firmware clears the lock. A SETUP packet always gets through, whatever the lock or halt bits say. The SETUP also primes the data stage with DATA1.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset all four registers read 0x00, no response is given and every toggle is DATA0. Register map: addr 0 holds enables of endpoints 1..3 in bits 2:0 and their direction in bits 6:4 (1 = IN). Addr 1 holds halt bits 2:0 and toggle-clear bits 6:4. Addr 2 holds the toggles of endpoints 1..3 in bits 2:0 and the endpoint-0 toggle in bit 7. Addr 3 holds lock (bit 0), saw-SETUP (1), saw-OUT (2), last PID (3), OUT halt (4) and IN halt (5).
- R2: A SETUP to endpoint 0 with a good CRC is always answered with ACK, even when the lock or either halt bit is set. It clears both endpoint-0 halt bits and sets the endpoint-0 toggle to DATA1.
- R3: An accepted OUT or SETUP on endpoint 0 sets the lock bit. While the lock is set, an OUT to endpoint 0 gets NAK. Firmware writing 0 to the lock reopens the endpoint.
- R4: On each accepted receive on endpoint 0, saw-SETUP and saw-OUT show which kind of token it was, and last PID holds its data PID (0 = DATA0, 1 = DATA1). These three bits ignore writes.
- R5: With the endpoint-0 OUT halt set, a good OUT gets STALL. With the IN halt set, an IN gets STALL.
- R6: A set halt bit on endpoint 1..3 makes that endpoint answer STALL. The halt bit reads back what was written.
- R7: Writing 1 to a toggle-clear bit returns that endpoint's toggle to DATA0. The toggle-clear bits read as 0.
- R8: A toggle flips on an ACK sent for OUT data whose PID matches it, and on a host ACK after an IN data packet. Data with a mismatched PID is ACKed, but it changes neither the toggle nor the endpoint-0 status.
- R9: A token gets no response and leaves no pending transaction in any of these cases: it is addressed to a disabled endpoint, to an endpoint of the wrong direction, or to an endpoint number of N_EP or more; it is a SETUP to a non-zero endpoint; or its kind is the reserved code.
- R10: An OUT or SETUP data packet with a bad CRC gets no response and changes no status, lock or toggle.
- R11: An OUT to a non-halted endpoint 1..3 whose receive FIFO is not ready gets NAK. An IN to a non-halted endpoint whose transmit FIFO is not ready gets NAK.
- R12: An IN to a ready, non-halted endpoint requests a data packet carrying the current toggle in hs_pid. Without a host ACK before the next token, the toggle stays unchanged.
- R13: tok_kind codes are OUT = 0, IN = 1, SETUP = 2, reserved = 3. hs_code values are ACK = 0, NAK = 1, STALL = 2, DATA = 3. A response is a one-cycle hs_valid pulse in the cycle after the clock edge that samples the IN token or the data packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | One-cycle token pulse |
| tok_kind | input | 2 | Token kind (OUT, IN, SETUP) |
| tok_ep | input | TOK_EPW | Endpoint number of the token |
| data_valid | input | 1 | One-cycle pulse at the end of a data packet |
| data_pid | input | 1 | Data PID of the packet, 1 = DATA1 |
| data_crc_ok | input | 1 | CRC of the data packet was good |
| host_ack | input | 1 | Host returned ACK for device data |
| tx_ready | input | N_EP | Transmit data ready, one bit per endpoint |
| rx_ready | input | N_EP-1 | Receive space ready, endpoints 1..N_EP-1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| hs_valid | output | 1 | Response pulse |
| hs_code | output | 2 | Response code |
| hs_pid | output | 1 | Toggle to use for a DATA response |

## Verification
The assertions assume that a token, a data packet and a host ACK are single-cycle pulses. They also assume that a data packet counts only when it follows an OUT or SETUP token with no newer token in between. Several properties exclude the cycle in which a new token arrives, because a token always takes over from a pending transaction. The directed stimulus never lines up a register write with a bus event in the same cycle. The random stimulus runs one action per step with an idle cycle between actions, so the write-versus-event priority is never relied on by the checks.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_DATA  = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RXDATA = 2'd1,
        PH_TXACK  = 2'd2
    } phase_e;

    localparam logic [1:0] REG_ENDIR = 2'd0;
    localparam logic [1:0] REG_HALT  = 2'd1;
    localparam logic [1:0] REG_TOG   = 2'd2;
    localparam logic [1:0] REG_EP0   = 2'd3;
endpackage

// File: rtl/usb_hs_toggle.sv
module usb_hs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_one,
    input  logic flip,
    output logic tog_q
);
    logic tog_d;

    // Clear beats set, set beats flip.
    always_comb begin
        tog_d = tog_q;
        if (clr)          tog_d = 1'b0;
        else if (set_one) tog_d = 1'b1;
        else if (flip)    tog_d = ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    // R7
    tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tog_q);
endmodule

// File: rtl/usb_hs_resp.sv
module usb_hs_resp
    import usb_hs_pkg::*;
(
    input  logic is_in,
    input  logic halted,
    input  logic ready,
    output hs_e  code
);
    always_comb begin
        if (halted)     code = HS_STALL;
        else if (!ready) code = HS_NAK;
        else if (is_in)  code = HS_DATA;
        else             code = HS_ACK;
    end
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
    import usb_hs_pkg::*;
#(
    parameter int N_EP    = 4,
    parameter int TOK_EPW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tok_valid,
    input  logic [1:0]         tok_kind,
    input  logic [TOK_EPW-1:0] tok_ep,
    input  logic               data_valid,
    input  logic               data_pid,
    input  logic               data_crc_ok,
    input  logic               host_ack,
    input  logic [N_EP-1:0]    tx_ready,
    input  logic [N_EP-2:0]    rx_ready,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               hs_valid,
    output logic [1:0]         hs_code,
    output logic               hs_pid
);
    localparam int NX  = N_EP - 1;
    localparam int EPW = (N_EP > 1) ? $clog2(N_EP) : 1;
    localparam logic [7:0] USED_MASK = 8'((1 << NX) - 1) | 8'(((1 << NX) - 1) << 4);

    typedef struct packed {
        phase_e          phase;
        logic [EPW-1:0]  ep;
        logic            setup;
        logic            hs_valid;
        hs_e             hs_code;
        logic            hs_pid;
        logic [NX-1:0]   en;
        logic [NX-1:0]   dir_in;
        logic [NX-1:0]   halt;
        logic            ep0_lock;
        logic            ep0_saw_setup;
        logic            ep0_saw_out;
        logic            ep0_last_pid;
        logic            ep0_out_halt;
        logic            ep0_in_halt;
    } st_t;

    st_t q, d;

    tok_e           tk;
    logic           tok_in_range;
    logic [EPW-1:0] tok_idx;
    logic           tok_ok;
    logic           sel_in;
    logic [EPW-1:0] sel_ep;
    logic           sel_halt;
    logic           sel_ready;
    hs_e            resp_code;
    logic [N_EP-1:0] tog, tog_clr, tog_set, tog_flip;
    logic           unused_wbits;

    assign tk           = tok_e'(tok_kind);
    assign tok_in_range = int'(tok_ep) < N_EP;
    assign tok_idx      = tok_ep[EPW-1:0];
    assign unused_wbits = ^(reg_wdata & ~USED_MASK);

    // Token admission: endpoint present, enabled and facing the right way.
    always_comb begin
        tok_ok = 1'b0;
        if (tok_in_range && tk != TK_RSVD) begin
            if (tok_idx == '0) begin
                tok_ok = 1'b1;
            end else if (tk != TK_SETUP) begin
                tok_ok = q.en[tok_idx - 1'b1] &&
                         (q.dir_in[tok_idx - 1'b1] == (tk == TK_IN));
            end
        end
    end

    // Context for the shared response evaluator.
    always_comb begin
        sel_in = tok_valid && (tk == TK_IN);
        sel_ep = tok_valid ? tok_idx : q.ep;
        if (sel_ep == '0) begin
            sel_halt  = sel_in ? q.ep0_in_halt : q.ep0_out_halt;
            sel_ready = sel_in ? tx_ready[0] : !q.ep0_lock;
        end else begin
            sel_halt  = q.halt[sel_ep - 1'b1];
            sel_ready = sel_in ? tx_ready[sel_ep] : rx_ready[sel_ep - 1'b1];
        end
    end

    usb_hs_resp u_resp (
        .is_in  (sel_in),
        .halted (sel_halt),
        .ready  (sel_ready),
        .code   (resp_code)
    );

    for (genvar g = 0; g < N_EP; g++) begin : g_tog
        usb_hs_toggle u_tog (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (tog_clr[g]),
            .set_one (tog_set[g]),
            .flip    (tog_flip[g]),
            .tog_q   (tog[g])
        );
    end

    always_comb begin
        d          = q;
        d.hs_valid = 1'b0;
        tog_clr    = '0;
        tog_set    = '0;
        tog_flip   = '0;

        if (reg_wr) begin
            case (reg_addr)
                REG_ENDIR: begin
                    d.en     = reg_wdata[NX-1:0];
                    d.dir_in = reg_wdata[4 +: NX];
                end
                REG_HALT: begin
                    d.halt           = reg_wdata[NX-1:0];
                    tog_clr[N_EP-1:1] = reg_wdata[4 +: NX];
                end
                REG_EP0: begin
                    d.ep0_lock     = reg_wdata[0];
                    d.ep0_out_halt = reg_wdata[4];
                    d.ep0_in_halt  = reg_wdata[5];
                end
                default: ;
            endcase
        end

        if (tok_valid) begin
            d.phase = PH_IDLE;
            d.ep    = tok_idx;
            d.setup = (tk == TK_SETUP);
            if (tok_ok) begin
                if (tk == TK_IN) begin
                    d.hs_valid = 1'b1;
                    d.hs_code  = resp_code;
                    d.hs_pid   = tog[tok_idx];
                    if (resp_code == HS_DATA) d.phase = PH_TXACK;
                end else begin
                    d.phase = PH_RXDATA;
                end
            end
        end else if (q.phase == PH_RXDATA && data_valid) begin
            d.phase = PH_IDLE;
            if (data_crc_ok) begin
                d.hs_valid = 1'b1;
                if (q.setup) begin
                    d.hs_code       = HS_ACK;
                    d.ep0_lock      = 1'b1;
                    d.ep0_saw_setup = 1'b1;
                    d.ep0_saw_out   = 1'b0;
                    d.ep0_last_pid  = data_pid;
                    d.ep0_out_halt  = 1'b0;
                    d.ep0_in_halt   = 1'b0;
                    tog_set[0]      = 1'b1;
                end else begin
                    d.hs_code = resp_code;
                    if (resp_code == HS_ACK && data_pid == tog[q.ep]) begin
                        tog_flip[q.ep] = 1'b1;
                        if (q.ep == '0) begin
                            d.ep0_lock      = 1'b1;
                            d.ep0_saw_setup = 1'b0;
                            d.ep0_saw_out   = 1'b1;
                            d.ep0_last_pid  = data_pid;
                        end
                    end
                end
            end
        end else if (q.phase == PH_TXACK && host_ack) begin
            d.phase        = PH_IDLE;
            tog_flip[q.ep] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_ENDIR: begin
                reg_rdata[NX-1:0]  = q.en;
                reg_rdata[4 +: NX] = q.dir_in;
            end
            REG_HALT: reg_rdata[NX-1:0] = q.halt;
            REG_TOG: begin
                reg_rdata[NX-1:0] = tog[N_EP-1:1];
                reg_rdata[7]      = tog[0];
            end
            default: reg_rdata = {2'b00, q.ep0_in_halt, q.ep0_out_halt, q.ep0_last_pid,
                                  q.ep0_saw_out, q.ep0_saw_setup, q.ep0_lock};
        endcase
    end

    assign hs_valid = q.hs_valid;
    assign hs_code  = q.hs_code;
    assign hs_pid   = q.hs_pid;

    // R13
    data_waits_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == HS_DATA) |-> q.phase == PH_TXACK);

    // R2
    setup_always_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RXDATA && q.setup && data_valid && data_crc_ok && !tok_valid)
        |=> (hs_valid && hs_code == HS_ACK && tog[0] && !q.ep0_out_halt && !q.ep0_in_halt));

    // R10
    bad_crc_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RXDATA && data_valid && !data_crc_ok && !tok_valid)
        |=> (!hs_valid && $stable(tog)));

    // R3
    lock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ep0_lock) |-> ((hs_valid && hs_code == HS_ACK) ||
                               $past(reg_wr && reg_addr == REG_EP0)));

    // R9
    bad_ep_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && (!tok_in_range || (tk == TK_SETUP && tok_ep != '0)))
        |=> (!hs_valid && q.phase == PH_IDLE));
endmodule

// File: tb/tb_usb_ep_handshake.sv
`timescale 1ns/1ps
module tb_usb_ep_handshake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic [3:0] tok_ep = 4'd0;
    logic       data_valid = 1'b0;
    logic       data_pid = 1'b0;
    logic       data_crc_ok = 1'b0;
    logic       host_ack = 1'b0;
    logic [3:0] tx_ready = 4'd0;
    logic [2:0] rx_ready = 3'd0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       hs_pid;

    int checks = 0;
    int errors = 0;
    string req = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_ep_handshake dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_ep(tok_ep), .data_valid(data_valid), .data_pid(data_pid),
        .data_crc_ok(data_crc_ok), .host_ack(host_ack), .tx_ready(tx_ready),
        .rx_ready(rx_ready), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hs_valid(hs_valid),
        .hs_code(hs_code), .hs_pid(hs_pid)
    );

    // Behavioural model
    bit m_en[4], m_dir[4], m_halt[4], m_tog[4];
    bit m_lock, m_saw_setup, m_saw_out, m_last_pid, m_out_halt, m_in_halt;
    int m_phase;     // 0 idle, 1 waiting data, 2 waiting host ack
    int m_cur;
    bit m_setup;
    bit e_valid;
    int e_code;
    bit e_pid;

    function automatic int model_resp(int ep, bit is_in);
        bit stall, rdy;
        if (ep == 0) begin
            stall = is_in ? m_in_halt : m_out_halt;
            rdy   = is_in ? tx_ready[0] : !m_lock;
        end else begin
            stall = m_halt[ep];
            rdy   = is_in ? tx_ready[ep] : rx_ready[ep-1];
        end
        if (stall) return 2;
        if (!rdy) return 1;
        return is_in ? 3 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                m_en[k] = 0; m_dir[k] = 0; m_halt[k] = 0; m_tog[k] = 0;
            end
            m_lock = 0; m_saw_setup = 0; m_saw_out = 0; m_last_pid = 0;
            m_out_halt = 0; m_in_halt = 0; m_phase = 0; m_cur = 0; m_setup = 0;
            e_valid = 0; e_code = 0; e_pid = 0;
        end else begin
            int ep, kind, r;
            bit ok;
            bit clr[4];
            for (int k = 0; k < 4; k++) clr[k] = 0;
            e_valid = 0;
            if (tok_valid) begin
                ep = int'(tok_ep); kind = int'(tok_kind);
                if (ep >= 4 || kind == 3) ok = 0;
                else if (ep == 0) ok = 1;
                else ok = (kind == 0 || kind == 1) && m_en[ep] && (m_dir[ep] == (kind == 1));
                m_phase = 0;
                if (ok) begin
                    m_cur = ep;
                    if (kind == 1) begin
                        r = model_resp(ep, 1);
                        e_valid = 1; e_code = r; e_pid = m_tog[ep];
                        if (r == 3) m_phase = 2;
                    end else begin
                        m_phase = 1; m_setup = (kind == 2);
                    end
                end
            end else if (m_phase == 1 && data_valid) begin
                m_phase = 0;
                if (data_crc_ok) begin
                    e_valid = 1;
                    if (m_setup) begin
                        e_code = 0; m_lock = 1; m_saw_setup = 1; m_saw_out = 0;
                        m_last_pid = data_pid; m_out_halt = 0; m_in_halt = 0; m_tog[0] = 1;
                    end else begin
                        r = model_resp(m_cur, 0);
                        e_code = r;
                        if (r == 0 && data_pid == m_tog[m_cur]) begin
                            m_tog[m_cur] = !m_tog[m_cur];
                            if (m_cur == 0) begin
                                m_lock = 1; m_saw_out = 1; m_saw_setup = 0; m_last_pid = data_pid;
                            end
                        end
                    end
                end
            end else if (m_phase == 2 && host_ack) begin
                m_phase = 0;
                m_tog[m_cur] = !m_tog[m_cur];
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: for (int k = 1; k < 4; k++) begin
                        m_en[k] = reg_wdata[k-1]; m_dir[k] = reg_wdata[k+3];
                    end
                    2'd1: for (int k = 1; k < 4; k++) begin
                        m_halt[k] = reg_wdata[k-1]; clr[k] = reg_wdata[k+3];
                    end
                    2'd3: begin
                        m_lock = reg_wdata[0]; m_out_halt = reg_wdata[4]; m_in_halt = reg_wdata[5];
                    end
                    default: ;
                endcase
            end
            for (int k = 1; k < 4; k++) if (clr[k]) m_tog[k] = 0;
        end
    end

    function automatic logic [7:0] model_read(int a);
        logic [7:0] v = 8'd0;
        case (a)
            0: for (int k = 1; k < 4; k++) begin v[k-1] = m_en[k]; v[k+3] = m_dir[k]; end
            1: for (int k = 1; k < 4; k++) v[k-1] = m_halt[k];
            2: begin for (int k = 1; k < 4; k++) v[k-1] = m_tog[k]; v[7] = m_tog[0]; end
            default: v = {2'b00, m_in_halt, m_out_halt, m_last_pid, m_saw_out, m_saw_setup, m_lock};
        endcase
        return v;
    endfunction

    // Per-cycle comparison of the response outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (hs_valid !== e_valid ||
                (e_valid && (hs_code !== 2'(e_code) || (e_code == 3 && hs_pid !== e_pid)))) begin
                errors++;
                $display("FAIL %s: response act v=%0b code=%0d pid=%0b exp v=%0b code=%0d pid=%0b",
                         req, hs_valid, hs_code, hs_pid, e_valid, e_code, e_pid);
            end
        end
    end

    task automatic rd(input int a);
        reg_addr = 2'(a);
        #1;
        checks++;
        if (reg_rdata !== model_read(a)) begin
            errors++;
            $display("FAIL %s: reg %0d act %02h exp %02h", req, a, reg_rdata, model_read(a));
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int v);
        reg_wr = 1; reg_addr = 2'(a); reg_wdata = 8'(v);
        step(1);
        reg_wr = 0;
    endtask

    task automatic tok(input int kind, input int ep);
        tok_valid = 1; tok_kind = 2'(kind); tok_ep = 4'(ep);
        step(1);
        tok_valid = 0;
    endtask

    task automatic dat(input bit pid, input bit crc);
        data_valid = 1; data_pid = pid; data_crc_ok = crc;
        step(1);
        data_valid = 0;
    endtask

    task automatic hack();
        host_ack = 1;
        step(1);
        host_ack = 0;
    endtask

    task automatic rx_tx(input int kind, input int ep, input bit pid, input bit crc);
        tok(kind, ep); step(1); dat(pid, crc); step(1);
    endtask

    task automatic in_tx(input int ep);
        tok(1, ep); step(1);
    endtask

    task automatic expect_code(input int code);
        checks++;
        if (e_code != code) begin
            errors++;
            $display("FAIL %s: model code act %0d exp %0d", req, e_code, code);
        end
    endtask

    initial begin
        step(3);
        req = "R1";
        checks++;
        if (hs_valid !== 1'b0) begin
            errors++; $display("FAIL R1: hs_valid in reset act %0b exp 0", hs_valid);
        end
        rst_n = 1;
        step(2);
        for (int a = 0; a < 4; a++) rd(a);

        req = "R9";
        rx_tx(0, 1, 0, 1);          // endpoint 1 disabled
        in_tx(2);
        wr(0, 8'h27);               // en 1..3, ep2 IN
        rd(0);
        rx_tx(2, 1, 0, 1);          // SETUP to ep1
        in_tx(1);                   // IN to OUT endpoint
        rx_tx(0, 5, 0, 1);          // out of range
        rx_tx(3, 0, 0, 1);          // reserved kind

        req = "R2";
        wr(3, 8'h31);               // lock + both halts
        rx_tx(2, 0, 0, 1);
        expect_code(0);
        rd(3); rd(2);

        req = "R4";
        rd(3);
        wr(3, 8'h0E);               // read-only bits ignore writes
        rd(3);

        req = "R3";
        wr(3, 8'h01);
        rx_tx(0, 0, 1, 1);
        expect_code(1);
        wr(3, 8'h00);
        rx_tx(0, 0, 1, 1);
        expect_code(0);
        rd(3); rd(2);

        req = "R8";
        wr(3, 8'h00);
        rx_tx(0, 0, 1, 1);          // toggle now DATA0, PID mismatch
        rd(3); rd(2);

        req = "R12";
        tx_ready = 4'b0000;
        in_tx(0);
        expect_code(1);
        tx_ready = 4'b1111;
        in_tx(0);
        expect_code(3);
        hack(); step(1);
        rd(2);

        req = "R5";
        wr(3, 8'h30);
        rx_tx(0, 0, 0, 1);
        expect_code(2);
        in_tx(0);
        expect_code(2);
        rx_tx(2, 0, 0, 1);          // SETUP reopens
        rd(3);

        req = "R11";
        rx_ready = 3'b000;
        rx_tx(0, 1, 0, 1);
        expect_code(1);
        tx_ready = 4'b0000;
        in_tx(2);
        expect_code(1);
        rx_ready = 3'b111; tx_ready = 4'b1111;

        req = "R8";
        rx_tx(0, 1, 0, 1);
        rx_tx(0, 1, 1, 1);
        rx_tx(0, 3, 0, 1);
        rd(2);
        in_tx(2); hack(); step(1);
        rd(2);

        req = "R7";
        wr(1, 8'h70);
        rd(2); rd(1);

        req = "R6";
        wr(1, 8'h04);
        rx_tx(0, 3, 0, 1);
        expect_code(2);
        rd(1);
        wr(1, 8'h00);

        req = "R12";
        in_tx(2);
        expect_code(3);
        step(1);
        in_tx(2);                   // no host ack: same toggle again
        rd(2);

        req = "R10";
        rx_tx(0, 1, 1, 0);
        rx_tx(2, 0, 1, 0);
        rd(2); rd(3);

        req = "R13";
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom % 9);
            case (r)
                0: in_tx(int'($urandom % 6));
                1, 2: rx_tx(0, int'($urandom % 6), 1'($urandom), ($urandom % 5) != 0);
                3: rx_tx(2, int'($urandom % 2), 1'($urandom), 1'b1);
                4: hack();
                5: wr(int'($urandom % 4), int'($urandom % 256));
                6: begin tx_ready = 4'($urandom); rx_ready = 3'($urandom); end
                7: rd(int'($urandom % 4));
                default: dat(1'($urandom), 1'b1);
            endcase
            step(1);
        end
        for (int a = 0; a < 4; a++) rd(a);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R13: watchdog act hung exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule